// File: doc/BRIEF.md
# Stereo Image Widener

This block makes a stereo pair sound wider. Each frame it takes one signed left and one signed right sample. It forms the side signal (left minus right) and smooths it with a first-order low-pass filter, so that only the low-frequency part remains. It scales that part by a programmable level, adds the result to the left channel and subtracts it from the right. Content that is identical in both channels has a zero side signal, so it leaves the block unchanged.

Two 2.20 parameters control the block: the filter coefficient, which sets the cutoff and is normally chosen for roughly 500 Hz to 2 kHz, and the widening level. Software writes them through a small register port into shadow registers. A shadow value becomes active only when a new frame is accepted, so the parameters never change while a frame is being computed. Audio samples are 3.23 two's complement. Outputs clip at the ends of that range.

Top module: `stereo_widener`

## Requirements
- R1: When the filtered side signal is zero, the outputs equal the inputs. In particular, after reset a stream with left equal to right passes through unchanged for any parameter values.
- R2: With side d = left − right, the filter keeps a state y with 20 fraction bits below the sample LSB and updates it once per frame as y ← y + alpha·(d − y). The product is floored at the state LSB. The filter output w is the state floored to the sample LSB.
- R3: The widening term is s = floor(w · level / 2^20), where level and alpha are two's complement 2.20 values (1.0 = 0x100000, −2.0 = 0x200000 in 22 bits).
- R4: Before clipping, left_o = left_i + s and right_o = right_i − s. The widening term enters the two channels with opposite polarity.
- R5: Each output clips to the 26-bit 3.23 range, from −2^25 to 2^25 − 1, and never wraps.
- R6: A frame strobed on valid_i at one rising edge appears on the outputs with valid_o high after the third rising edge, counting the strobe edge. valid_o is low in the cycles in between. The outputs hold their values whenever valid_o is low.
- R7: A write with wr_sel_i = 0 targets alpha and one with wr_sel_i = 1 targets level. A write applies to the first frame strobed at a later edge than the write. A write in the same cycle as a strobe, or while a frame is in flight, does not affect that frame.
- R8: Reset clears both parameters, the filter state and the outputs, and drops valid_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Frame strobe, one cycle per sample pair |
| left_i | input | DATA_W | Left sample, 3.23 two's complement |
| right_i | input | DATA_W | Right sample, 3.23 two's complement |
| wr_en_i | input | 1 | Parameter write enable |
| wr_sel_i | input | 1 | Parameter select: 0 alpha, 1 level |
| wr_data_i | input | COEF_W | Parameter value, 2.20 two's complement |
| valid_o | output | 1 | Output frame valid |
| left_o | output | DATA_W | Widened left sample |
| right_o | output | DATA_W | Widened right sample |

## Verification
With alpha at 1.0 the filter output equals the side signal in every frame. That isolates the scaling and mixing stages, so a vector table can cover positive, negative and zero levels, a centre-panned pair, odd side values that expose floor rounding of negative products, and extreme inputs that drive both channels into opposite clip rails. A constant side step at alpha = 0.5 after reset gives an exact geometric approach (1/2, 3/4, 7/8 of the step), which separates correct state memory from a filter that ignores or loses its previous value. Writes placed in the strobe cycle and in the cycle after the strobe show whether parameters are captured per frame rather than taken live. A reset in mid-run followed by a frame shows that the parameters return to zero.

// File: rtl/sw_pkg.sv
package sw_pkg;
  localparam int DEF_DATA_W    = 26;  // 3.23 samples
  localparam int DEF_COEF_W    = 22;  // 2.20 parameters
  localparam int DEF_COEF_FRAC = 20;
  localparam int N_PARAM       = 2;
  localparam int PSEL_W        = 1;

  typedef enum logic [PSEL_W-1:0] {
    PSEL_ALPHA = 1'b0,
    PSEL_LEVEL = 1'b1
  } psel_e;
endpackage

// File: rtl/sw_sat.sv
module sw_sat #(
  parameter int IN_W  = 30,
  parameter int OUT_W = 26
) (
  input  logic signed [IN_W-1:0]  x_i,
  output logic signed [OUT_W-1:0] y_o
);
  localparam logic signed [IN_W-1:0] MAXV = {{(IN_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
  localparam logic signed [IN_W-1:0] MINV = ~MAXV;

  always_comb begin
    if (x_i > MAXV)      y_o = MAXV[OUT_W-1:0];
    else if (x_i < MINV) y_o = MINV[OUT_W-1:0];
    else                 y_o = x_i[OUT_W-1:0];
  end
endmodule

// File: rtl/sw_param_bank.sv
module sw_param_bank
  import sw_pkg::*;
#(
  parameter int COEF_W = DEF_COEF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [PSEL_W-1:0] wr_sel_i,
  input  logic [COEF_W-1:0] wr_data_i,
  input  logic              frame_i,
  output logic [COEF_W-1:0] alpha_o,
  output logic [COEF_W-1:0] level_o
);
  logic [COEF_W-1:0] shadow_q [N_PARAM];
  logic [COEF_W-1:0] active_q [N_PARAM];

  for (genvar g = 0; g < N_PARAM; g++) begin : g_param
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        shadow_q[g] <= '0;
        active_q[g] <= '0;
      end else begin
        if (wr_en_i && (wr_sel_i == PSEL_W'(g))) shadow_q[g] <= wr_data_i;
        // promote only on a frame strobe; same-cycle write lands next frame
        if (frame_i) active_q[g] <= shadow_q[g];
      end
    end
  end

  assign alpha_o = active_q[PSEL_ALPHA];
  assign level_o = active_q[PSEL_LEVEL];
endmodule

// File: rtl/sw_diff_lpf.sv
module sw_diff_lpf
  import sw_pkg::*;
#(
  parameter int DATA_W    = DEF_DATA_W,
  parameter int COEF_W    = DEF_COEF_W,
  parameter int COEF_FRAC = DEF_COEF_FRAC
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic signed [DATA_W-1:0] left_i,
  input  logic signed [DATA_W-1:0] right_i,
  input  logic signed [COEF_W-1:0] alpha_i,
  output logic                     valid_o,
  output logic signed [DATA_W-1:0] left_o,
  output logic signed [DATA_W-1:0] right_o,
  output logic signed [DATA_W:0]   side_o
);
  localparam int D_W  = DATA_W + 1;
  localparam int ST_W = D_W + COEF_FRAC;
  localparam int P_W  = ST_W + 1 + COEF_W;

  logic                     v1_q;
  logic signed [DATA_W-1:0] l1_q, r1_q;
  logic signed [D_W-1:0]    d1_q;
  logic signed [ST_W-1:0]   y_q;

  logic signed [P_W-1:0]  d_ext, y_ext, a_ext, err, prod, step, y_sum;
  logic signed [ST_W-1:0] y_sat;

  // stage 1: side signal
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v1_q <= 1'b0;
      l1_q <= '0;
      r1_q <= '0;
      d1_q <= '0;
    end else begin
      v1_q <= valid_i;
      if (valid_i) begin
        l1_q <= left_i;
        r1_q <= right_i;
        d1_q <= $signed({left_i[DATA_W-1], left_i}) - $signed({right_i[DATA_W-1], right_i});
      end
    end
  end

  // state update: y + alpha*(d - y), full state precision
  assign d_ext = {{(P_W-ST_W){d1_q[D_W-1]}}, d1_q, {COEF_FRAC{1'b0}}};
  assign y_ext = {{(P_W-ST_W){y_q[ST_W-1]}}, y_q};
  assign a_ext = {{(P_W-COEF_W){alpha_i[COEF_W-1]}}, alpha_i};
  assign err   = d_ext - y_ext;
  assign prod  = err * a_ext;
  assign step  = prod >>> COEF_FRAC;
  assign y_sum = y_ext + step;

  sw_sat #(.IN_W(P_W), .OUT_W(ST_W)) u_state_sat (
    .x_i (y_sum),
    .y_o (y_sat)
  );

  // stage 2: filter state and filtered side
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      y_q     <= '0;
      side_o  <= '0;
      left_o  <= '0;
      right_o <= '0;
    end else begin
      valid_o <= v1_q;
      if (v1_q) begin
        y_q     <= y_sat;
        side_o  <= y_sat[ST_W-1:COEF_FRAC];
        left_o  <= l1_q;
        right_o <= r1_q;
      end
    end
  end
endmodule

// File: rtl/sw_mix.sv
module sw_mix
  import sw_pkg::*;
#(
  parameter int DATA_W    = DEF_DATA_W,
  parameter int COEF_W    = DEF_COEF_W,
  parameter int COEF_FRAC = DEF_COEF_FRAC
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic signed [DATA_W-1:0] left_i,
  input  logic signed [DATA_W-1:0] right_i,
  input  logic signed [DATA_W:0]   side_i,
  input  logic signed [COEF_W-1:0] level_i,
  output logic                     valid_o,
  output logic signed [DATA_W-1:0] left_o,
  output logic signed [DATA_W-1:0] right_o
);
  localparam int D_W = DATA_W + 1;
  localparam int S_W = D_W + COEF_W;

  logic signed [S_W-1:0]    w_ext, lv_ext, prod, wide;
  logic signed [S_W-1:0]    sum [2];
  logic signed [DATA_W-1:0] ch_in [2];
  logic signed [DATA_W-1:0] ch_sat [2];

  assign w_ext  = {{(S_W-D_W){side_i[D_W-1]}}, side_i};
  assign lv_ext = {{(S_W-COEF_W){level_i[COEF_W-1]}}, level_i};
  assign prod   = w_ext * lv_ext;
  assign wide   = prod >>> COEF_FRAC;

  assign ch_in[0] = left_i;
  assign ch_in[1] = right_i;

  for (genvar c = 0; c < 2; c++) begin : g_ch
    logic signed [S_W-1:0] in_ext;
    assign in_ext = {{(S_W-DATA_W){ch_in[c][DATA_W-1]}}, ch_in[c]};
    if (c == 0) begin : g_add
      assign sum[c] = in_ext + wide;
    end else begin : g_sub
      assign sum[c] = in_ext - wide;
    end
    sw_sat #(.IN_W(S_W), .OUT_W(DATA_W)) u_out_sat (
      .x_i (sum[c]),
      .y_o (ch_sat[c])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      left_o  <= '0;
      right_o <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        left_o  <= ch_sat[0];
        right_o <= ch_sat[1];
      end
    end
  end
endmodule

// File: rtl/stereo_widener.sv
module stereo_widener
  import sw_pkg::*;
#(
  parameter int DATA_W    = DEF_DATA_W,
  parameter int COEF_W    = DEF_COEF_W,
  parameter int COEF_FRAC = DEF_COEF_FRAC
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] left_i,
  input  logic [DATA_W-1:0] right_i,
  input  logic              wr_en_i,
  input  logic [PSEL_W-1:0] wr_sel_i,
  input  logic [COEF_W-1:0] wr_data_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] left_o,
  output logic [DATA_W-1:0] right_o
);
  logic [COEF_W-1:0]        alpha_act, level_act;
  logic                     v2;
  logic signed [DATA_W-1:0] l2, r2;
  logic signed [DATA_W:0]   w2;
  logic signed [COEF_W-1:0] level_p2;
  logic signed [DATA_W-1:0] l_out, r_out;

  sw_param_bank #(.COEF_W(COEF_W)) u_params (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (wr_sel_i),
    .wr_data_i (wr_data_i),
    .frame_i   (valid_i),
    .alpha_o   (alpha_act),
    .level_o   (level_act)
  );

  sw_diff_lpf #(.DATA_W(DATA_W), .COEF_W(COEF_W), .COEF_FRAC(COEF_FRAC)) u_lpf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .left_i  ($signed(left_i)),
    .right_i ($signed(right_i)),
    .alpha_i ($signed(alpha_act)),
    .valid_o (v2),
    .left_o  (l2),
    .right_o (r2),
    .side_o  (w2)
  );

  // level travels with its frame so a following strobe cannot overwrite it
  logic v1_shadow;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v1_shadow <= 1'b0;
      level_p2  <= '0;
    end else begin
      v1_shadow <= valid_i;
      if (v1_shadow) level_p2 <= $signed(level_act);
    end
  end

  sw_mix #(.DATA_W(DATA_W), .COEF_W(COEF_W), .COEF_FRAC(COEF_FRAC)) u_mix (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (v2),
    .left_i  (l2),
    .right_i (r2),
    .side_i  (w2),
    .level_i (level_p2),
    .valid_o (valid_o),
    .left_o  (l_out),
    .right_o (r_out)
  );

  assign left_o  = l_out;
  assign right_o = r_out;
endmodule

// File: rtl/sw_checker.sv
module sw_checker #(
  parameter int DATA_W = 26,
  parameter int COEF_W = 22
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     valid_i,
  input logic                     valid_o,
  input logic signed [DATA_W-1:0] left_o,
  input logic signed [DATA_W-1:0] right_o,
  input logic signed [DATA_W-1:0] l2,
  input logic signed [DATA_W-1:0] r2,
  input logic signed [DATA_W:0]   w2,
  input logic [COEF_W-1:0]        alpha_act,
  input logic [COEF_W-1:0]        level_act
);
  localparam logic signed [DATA_W-1:0] RAIL_HI = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic signed [DATA_W-1:0] RAIL_LO = {1'b1, {(DATA_W-1){1'b0}}};

  logic [1:0] cyc_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cyc_q <= '0;
    else if (cyc_q != 2'd3) cyc_q <= cyc_q + 2'd1;
  end

  logic signed [DATA_W:0] out_sum, in_sum;
  logic                   unclipped;
  assign out_sum   = {left_o[DATA_W-1], left_o} + {right_o[DATA_W-1], right_o};
  assign in_sum    = {l2[DATA_W-1], l2} + {r2[DATA_W-1], r2};
  assign unclipped = (left_o != RAIL_HI) && (left_o != RAIL_LO) &&
                     (right_o != RAIL_HI) && (right_o != RAIL_LO);

  p_latency_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q == 2'd3) |-> (valid_o == $past(valid_i, 3)));

  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q != 2'd0 && !valid_o) |-> ($stable(left_o) && $stable(right_o)));

  p_passthru_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q != 2'd0 && valid_o && $past(w2 == '0)) |->
      (left_o == $past(l2) && right_o == $past(r2)));

  p_antiphase_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q != 2'd0 && valid_o && unclipped) |-> (out_sum == $past(in_sum)));

  p_param_frame_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q != 2'd0 && !($stable(alpha_act) && $stable(level_act))) |-> $past(valid_i));
endmodule

bind stereo_widener sw_checker #(.DATA_W(DATA_W), .COEF_W(COEF_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .valid_i   (valid_i),
  .valid_o   (valid_o),
  .left_o    ($signed(left_o)),
  .right_o   ($signed(right_o)),
  .l2        (l2),
  .r2        (r2),
  .w2        (w2),
  .alpha_act (alpha_act),
  .level_act (level_act)
);

// File: tb/stereo_widener_tb.sv
`timescale 1ns/1ps
module stereo_widener_tb;
  localparam int DATA_W = 26;
  localparam int COEF_W = 22;
  localparam int ONE_C  = 1048576;   // 1.0 in 2.20
  localparam int HALF_C = 524288;
  localparam int U      = 8388608;   // 1.0 in 3.23
  localparam int S_MAX  = 33554431;
  localparam int S_MIN  = -33554432;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic valid_i = 1'b0;
  logic [DATA_W-1:0] left_i = '0, right_i = '0;
  logic wr_en_i = 1'b0;
  logic [0:0] wr_sel_i = '0;
  logic [COEF_W-1:0] wr_data_i = '0;
  logic valid_o;
  logic signed [DATA_W-1:0] left_o, right_o;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk_i = ~clk_i;

  stereo_widener u_dut (
    .clk_i, .rst_ni, .valid_i, .left_i, .right_i,
    .wr_en_i, .wr_sel_i, .wr_data_i,
    .valid_o, .left_o, .right_o
  );

  // {req, left, right, level, exp_left, exp_right}; alpha fixed at 1.0
  localparam int NV = 9;
  localparam int VEC [NV][6] = '{
    '{4, U/2,      0,        HALF_C,   6291456,   -2097152},
    '{1, 3000000,  3000000,  ONE_C,    3000000,   3000000},
    '{4, 0,        U/2,      ONE_C,    -4194304,  8388608},
    '{5, 3*U,      -3*U,     ONE_C,    S_MAX,     S_MIN},
    '{3, U,        0,        -HALF_C,  4194304,   4194304},
    '{3, 1234567,  -7654321, 0,        1234567,   -7654321},
    '{3, 3,        0,        HALF_C,   4,         -1},
    '{3, -3,       0,        HALF_C,   -5,        2},
    '{5, S_MAX,    S_MIN,    -2*ONE_C, S_MIN,     S_MAX}
  };

  function automatic string rq(int n);
    case (n)
      1: return "R1";
      2: return "R2";
      3: return "R3";
      4: return "R4";
      5: return "R5";
      6: return "R6";
      7: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(int sel, int data);
    wr_en_i = 1'b1; wr_sel_i = 1'(sel); wr_data_i = data[COEF_W-1:0];
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  // strobe, confirm valid_o low for two cycles, high on the third (R6)
  task automatic frame(string req, int l, int r, int el, int er);
    valid_i = 1'b1; left_i = l[DATA_W-1:0]; right_i = r[DATA_W-1:0];
    @(negedge clk_i);
    valid_i = 1'b0;
    check("R6", int'(valid_o), 0);
    @(negedge clk_i);
    check("R6", int'(valid_o), 0);
    @(negedge clk_i);
    check("R6", int'(valid_o), 1);
    check(req, int'(left_o), el);
    check(req, int'(right_o), er);
  endtask

  initial begin
    #500000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    // R8: reset state
    #12;
    check("R8", int'(valid_o), 0);
    check("R8", int'(left_o), 0);
    check("R8", int'(right_o), 0);
    @(negedge clk_i); rst_ni = 1'b1;
    @(negedge clk_i);

    // R1: centre content from reset with nonzero parameters
    wr(0, HALF_C);
    wr(1, ONE_C);
    frame("R1", 5000000, 5000000, 5000000, 5000000);
    frame("R1", -777, -777, -777, -777);

    // vector table with alpha = 1.0
    wr(0, ONE_C);
    for (int i = 0; i < NV; i++) begin
      wr(1, VEC[i][3]);
      frame(rq(VEC[i][0]), VEC[i][1], VEC[i][2], VEC[i][4], VEC[i][5]);
    end

    // R6: outputs hold while idle
    repeat (3) @(negedge clk_i);
    check("R6", int'(left_o), S_MIN);
    check("R6", int'(right_o), S_MAX);

    // R7: write in strobe cycle does not affect that frame
    wr(1, 0);
    valid_i = 1'b1; left_i = 26'(U/2); right_i = '0;
    wr_en_i = 1'b1; wr_sel_i = 1'b1; wr_data_i = 22'(ONE_C);
    @(negedge clk_i);
    valid_i = 1'b0; wr_en_i = 1'b0;
    @(negedge clk_i); @(negedge clk_i);
    check("R7", int'(left_o), U/2);
    check("R7", int'(right_o), 0);
    frame("R7", U/2, 0, U, -U/2);
    // R7: write while frame in flight
    valid_i = 1'b1; left_i = 26'(U/2); right_i = '0;
    @(negedge clk_i);
    valid_i = 1'b0;
    wr(1, 0);
    @(negedge clk_i);
    check("R7", int'(left_o), U);
    check("R7", int'(right_o), -U/2);
    frame("R7", U/2, 0, U/2, 0);

    // R8: mid-run reset clears outputs and parameters
    wr(1, ONE_C);
    rst_ni = 1'b0;
    #1;
    check("R8", int'(valid_o), 0);
    check("R8", int'(left_o), 0);
    @(negedge clk_i); rst_ni = 1'b1;
    @(negedge clk_i);
    frame("R8", 5000, 1000, 5000, 1000);

    // R2: step response at alpha = 0.5, level = 1.0, state cleared
    rst_ni = 1'b0;
    @(negedge clk_i); rst_ni = 1'b1;
    @(negedge clk_i);
    wr(0, HALF_C);
    wr(1, ONE_C);
    frame("R2", 4194304, 0, 6291456, -2097152);
    frame("R2", 4194304, 0, 7340032, -3145728);
    frame("R2", 4194304, 0, 7864320, -3670016);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule